// File: doc/BRIEF.md
# Three-Slot Receive Frame Pool with Arrival Ranking

This block sits behind a byte-level receiver for a single-wire consumer-electronics control bus. It holds up to three complete received frames, from header byte to last operand, in three independent slots. For every occupied slot it keeps a 2-bit age rank, so software can always empty the slots oldest-first. The receiver marks each frame with a start pulse, a run of byte strobes and an end pulse. Line decoding and destination-address filtering are done upstream of this block.

Software reaches the pool through a small register port. Through it, software reads the rank word, the frame lengths, the stored bytes and the per-slot ready flags. It also sets the operating mode and gives slots back to the pool. A slot is returned only when its clear bit is written to one and later written back to zero. The remaining ranks then close up, so they always run densely from 1. Register map (6-bit address): 0x00 control, 0x01 status, 0x02 ready flags, 0x04 to 0x06 lengths of slots 0 to 2. Slot b's bytes start at 0x10 + 16*b.

Top module: `frame_pool`

## Requirements
- R1: After reset all ranks, ready flags and the overflow flag are zero, and the control register reads 0x08 (multi-slot mode on, all clear bits low).
- R2: A completed frame is stored in the lowest-numbered free slot. Its length reads at address 0x04+slot (5-bit field), and byte i reads at address 0x10+16*slot+i.
- R3: Status bits [1:0], [3:2] and [5:4] hold the rank of slots 0, 1 and 2. Rank 0 means empty, and 1, 2 and 3 mean oldest, second and third oldest. A new frame gets the rank one above the number of slots already occupied.
- R4: Completing a frame sets bit b of the ready register (0x02) and of the rx_irq output for its slot b. Writing a one to that bit clears it, and releasing the slot also clears it.
- R5: Control bits [2:0] are per-slot clear bits. A slot is released only when its clear bit is written from 1 to 0. Setting the bit alone leaves the slot occupied.
- R6: When slots are released, each remaining slot's rank drops by the number of released slots that were older than it.
- R7: A control write whose low four bits are 1111 releases every slot at once and clears the overflow flag.
- R8: A frame that starts while no slot is free is dropped, and the sticky overflow flag (status bit 6) is set.
- R9: A frame that delivers a 17th byte is discarded. No rank, length or ready flag changes.
- R10: A frame that ends with zero bytes is discarded. No rank or ready flag changes.
- R11: With control bit 3 low (single-slot mode), only slot 0 receives frames. A frame that arrives while slot 0 is occupied is dropped as in R8.
- R12: Read data for host_addr appears on host_rdata in the cycle after host_rd is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Frame-start pulse from the byte receiver |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Frame-end pulse |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 6 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| rx_irq | output | 3 | Per-slot ready flags |

## Verification
On every cycle, the assertions check the structure of the rank word: occupied ranks are unique and never exceed the occupied count. They also check that releases shrink the occupied count by exactly the number released, that ready flags belong only to occupied slots, and that a start with every slot full raises overflow. Only the bench scenarios can show slot choice and byte placement, the set-then-clear release sequence, rank renumbering for specific arrival orders, discarding of long and empty frames, and single-slot mode.

// File: rtl/frame_pool_pkg.sv
package frame_pool_pkg;
  localparam int NBUF      = 3;
  localparam int RANK_W    = 2;
  localparam int MAX_BYTES = 16;
  localparam int LEN_W     = $clog2(MAX_BYTES) + 1;
  localparam int BYTE_W    = $clog2(MAX_BYTES);
  localparam int BUF_W     = 2;
  localparam int DATA_W    = 8;
  localparam int HADDR_W   = 6;
  localparam int MODE_BIT  = 3;
  localparam int MEM_AW    = BUF_W + BYTE_W;
  localparam logic [HADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [HADDR_W-1:0] A_STAT = 6'h01;
  localparam logic [HADDR_W-1:0] A_IRQ  = 6'h02;
  localparam logic [HADDR_W-1:0] A_LEN0 = 6'h04;
endpackage

// File: rtl/fp_rank_track.sv
module fp_rank_track
  import frame_pool_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NBUF-1:0]          rel,
  input  logic                     commit,
  input  logic [BUF_W-1:0]         cbuf,
  output logic [NBUF*RANK_W-1:0]   rank_word,
  output logic [NBUF-1:0]          occ
);
  logic [RANK_W-1:0] rank_q [NBUF];
  logic [RANK_W-1:0] shift  [NBUF];
  logic [RANK_W-1:0] live_cnt;

  always_comb begin
    live_cnt = '0;
    for (int b = 0; b < NBUF; b++) begin
      occ[b] = (rank_q[b] != '0);
      rank_word[b*RANK_W +: RANK_W] = rank_q[b];
      if (occ[b] && !rel[b]) live_cnt = live_cnt + 1'b1;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    always_comb begin
      shift[b] = '0;
      for (int j = 0; j < NBUF; j++)
        if (rel[j] && occ[j] && rank_q[j] < rank_q[b]) shift[b] = shift[b] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)                                      rank_q[b] <= '0;
      else if (rel[b])                              rank_q[b] <= '0;
      else if (commit && cbuf == BUF_W'(b))         rank_q[b] <= live_cnt + 1'b1;
      else if (occ[b])                              rank_q[b] <= rank_q[b] - shift[b];
    end
  end
endmodule

// File: rtl/fp_rx_writer.sv
module fp_rx_writer
  import frame_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_start,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_end,
  input  logic [NBUF-1:0]   occ,
  input  logic              multi,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [BUF_W-1:0]  cbuf,
  output logic [LEN_W-1:0]  clen,
  output logic              ovf_set
);
  logic             active_q, bad_q;
  logic [BUF_W-1:0] tgt_q;
  logic [LEN_W-1:0] cnt_q;
  logic [NBUF-1:0]  freev;
  logic [BUF_W-1:0] pick;
  logic             any_free, full_cnt;

  always_comb begin
    freev    = ~occ & (multi ? {NBUF{1'b1}} : NBUF'(1));
    any_free = |freev;
    pick     = '0;
    for (int b = NBUF - 1; b >= 0; b--)
      if (freev[b]) pick = BUF_W'(b);
  end

  assign full_cnt = (cnt_q == LEN_W'(MAX_BYTES));
  assign ovf_set  = rx_start && !any_free;
  assign wr_en    = rx_valid && active_q && !rx_start && !full_cnt;
  assign wr_addr  = {tgt_q, cnt_q[BYTE_W-1:0]};
  assign wr_data  = rx_byte;
  assign commit   = rx_end && active_q && !rx_start && !bad_q && (cnt_q != '0);
  assign cbuf     = tgt_q;
  assign clen     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      tgt_q    <= '0;
      cnt_q    <= '0;
    end else if (rx_start) begin
      active_q <= any_free;
      bad_q    <= 1'b0;
      tgt_q    <= pick;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (rx_end)                   active_q <= 1'b0;
      else if (rx_valid && full_cnt) bad_q   <= 1'b1;
      else if (rx_valid)             cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fp_host_regs.sv
module fp_host_regs
  import frame_pool_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic [HADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  input  logic                   commit,
  input  logic [BUF_W-1:0]       cbuf,
  input  logic [LEN_W-1:0]       clen,
  input  logic                   ovf_set,
  input  logic [NBUF-1:0]        occ,
  input  logic [NBUF*RANK_W-1:0] rank_word,
  output logic [NBUF-1:0]        rel,
  output logic                   multi,
  output logic                   ovf,
  output logic [NBUF-1:0]        irq,
  output logic [DATA_W-1:0]      rd_word
);
  logic [MODE_BIT:0] ctrl_q;
  logic [LEN_W-1:0]  len_q [NBUF];
  logic              wr_ctrl, wipe;

  assign wr_ctrl = host_wr && host_addr == A_CTRL;
  assign wipe    = wr_ctrl && host_wdata[MODE_BIT:0] == '1;
  assign rel     = occ & ((wr_ctrl ? (ctrl_q[NBUF-1:0] & ~host_wdata[NBUF-1:0]) : '0)
                          | (wipe ? {NBUF{1'b1}} : '0));
  assign multi   = ctrl_q[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= (MODE_BIT+1)'(1 << MODE_BIT);
      ovf    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= host_wdata[MODE_BIT:0];
      if (ovf_set)   ovf <= 1'b1;
      else if (wipe) ovf <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        irq[b]   <= 1'b0;
        len_q[b] <= '0;
      end else if (commit && cbuf == BUF_W'(b)) begin
        irq[b]   <= 1'b1;
        len_q[b] <= clen;
      end else if (rel[b] || (host_wr && host_addr == A_IRQ && host_wdata[b])) begin
        irq[b]   <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (host_addr == A_CTRL)      rd_word = DATA_W'(ctrl_q);
    else if (host_addr == A_STAT) rd_word = DATA_W'({ovf, rank_word});
    else if (host_addr == A_IRQ)  rd_word = DATA_W'(irq);
    else
      for (int b = 0; b < NBUF; b++)
        if (host_addr == A_LEN0 + HADDR_W'(b)) rd_word = DATA_W'(len_q[b]);
  end
endmodule

// File: rtl/frame_pool.sv
module frame_pool
  import frame_pool_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_start,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_end,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [NBUF-1:0]    rx_irq
);
  logic [NBUF*RANK_W-1:0] rank_word;
  logic [NBUF-1:0]        occ, rel;
  logic                   multi, ovf, wr_en, commit, ovf_set;
  logic [MEM_AW-1:0]      wr_addr;
  logic [DATA_W-1:0]      wr_data, rd_word;
  logic [BUF_W-1:0]       cbuf;
  logic [LEN_W-1:0]       clen;
  logic [DATA_W-1:0]      mem [1 << MEM_AW];
  logic                   byte_win;
  logic [MEM_AW-1:0]      rd_addr;

  fp_rank_track u_rank (
    .clk(clk), .rst(rst), .rel(rel), .commit(commit), .cbuf(cbuf),
    .rank_word(rank_word), .occ(occ)
  );

  fp_rx_writer u_rx (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .occ(occ), .multi(multi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
    .cbuf(cbuf), .clen(clen), .ovf_set(ovf_set)
  );

  fp_host_regs u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .commit(commit), .cbuf(cbuf), .clen(clen),
    .ovf_set(ovf_set), .occ(occ), .rank_word(rank_word), .rel(rel),
    .multi(multi), .ovf(ovf), .irq(rx_irq), .rd_word(rd_word)
  );

  assign byte_win = host_addr[HADDR_W-1 -: BUF_W] != '0;
  assign rd_addr  = {host_addr[HADDR_W-1 -: BUF_W] - 1'b1, host_addr[BYTE_W-1:0]};

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= byte_win ? mem[rd_addr] : rd_word;
  end
endmodule

module frame_pool_chk
  import frame_pool_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic [NBUF*RANK_W-1:0] rank_word,
  input logic [NBUF-1:0]        occ,
  input logic [NBUF-1:0]        rel,
  input logic [NBUF-1:0]        irq,
  input logic                   commit,
  input logic                   rx_start,
  input logic                   ovf
);
  logic [RANK_W-1:0] r0, r1, r2;
  assign r0 = rank_word[1:0];
  assign r1 = rank_word[3:2];
  assign r2 = rank_word[5:4];

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (rank_word == '0 && irq == '0 && !ovf));

  a_r3_rank_unique: assert property (@(posedge clk) disable iff (rst)
    (r0 == 0 || (r0 != r1 && r0 != r2)) && (r1 == 0 || r1 != r2));

  a_r3_rank_bound: assert property (@(posedge clk) disable iff (rst)
    r0 <= $countones(occ) && r1 <= $countones(occ) && r2 <= $countones(occ));

  a_r4_irq_needs_frame: assert property (@(posedge clk) disable iff (rst)
    (irq & ~occ) == '0);

  a_r6_release_count: assert property (@(posedge clk) disable iff (rst)
    (rel != '0 && !commit) |=> $countones(occ) == $past($countones(occ)) - $past($countones(rel)));

  a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_start && occ == '1) |=> ovf);
endmodule

bind frame_pool frame_pool_chk u_chk (
  .clk(clk), .rst(rst), .rank_word(rank_word), .occ(occ), .rel(rel),
  .irq(rx_irq), .commit(commit), .rx_start(rx_start), .ovf(ovf)
);

// File: tb/frame_pool_bench.sv
module frame_pool_bench;
  logic       clk = 1'b0, rst = 1'b1;
  logic       rx_start = 0, rx_valid = 0, rx_end = 0;
  logic [7:0] rx_byte = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [5:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic [2:0] rx_irq;

  int total = 0, bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  frame_pool u_frame_pool (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_irq(rx_irq)
  );

  // monitor: R12 read data is compared one cycle after the strobe is sampled
  always @(posedge clk) rd_seen <= host_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (host_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %02h expected %02h", t, host_rdata, e);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic frame(input int n, input logic [7:0] base);
    @(negedge clk);
    rx_start = 1;
    @(negedge clk);
    rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = base + 8'(i);
      @(negedge clk);
    end
    rx_valid = 0;
    rx_end = 1;
    @(negedge clk);
    rx_end = 0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    @(negedge clk);
    total++;
    if (rx_irq !== e) begin
      bad++;
      $display("FAIL %s: rx_irq got %0h expected %0h", t, rx_irq, e);
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(6'h01, 8'h00, "R1 status after reset");
    rd(6'h00, 8'h08, "R1 ctrl after reset");
    rd(6'h02, 8'h00, "R1 ready after reset");
    chk_irq(3'b000, "R1 rx_irq after reset");

    frame(3, 8'h40);
    rd(6'h04, 8'h03, "R2 len slot0");
    rd(6'h10, 8'h40, "R2 slot0 byte0");
    rd(6'h12, 8'h42, "R2 slot0 byte2 (R12 timing)");
    rd(6'h01, 8'h01, "R3 rank first frame");
    chk_irq(3'b001, "R4 irq slot0");

    frame(16, 8'h80);
    rd(6'h01, 8'h09, "R3 rank second frame");
    rd(6'h05, 8'h10, "R2 len slot1 = 16");
    rd(6'h2F, 8'h8F, "R2 slot1 last byte");

    wr(6'h02, 8'h01);
    rd(6'h02, 8'h02, "R4 write-one clears ready");

    wr(6'h00, 8'h09);
    rd(6'h01, 8'h09, "R5 set alone keeps slot");
    wr(6'h00, 8'h08);
    rd(6'h01, 8'h04, "R6 release renumbers");

    frame(2, 8'h10);
    rd(6'h01, 8'h06, "R3 reuse lowest free slot");
    rd(6'h11, 8'h11, "R2 reused slot0 byte1");
    frame(1, 8'hA0);
    rd(6'h01, 8'h36, "R3 third rank");
    frame(2, 8'hC0);
    rd(6'h01, 8'h76, "R8 full drop sets overflow");
    rd(6'h30, 8'hA0, "R8 stored byte untouched");
    chk_irq(3'b111, "R4 irq all slots");

    wr(6'h00, 8'h0A);
    wr(6'h00, 8'h08);
    rd(6'h01, 8'h61, "R6 oldest released, others drop");
    chk_irq(3'b101, "R4 release clears ready");

    frame(17, 8'h55);
    rd(6'h01, 8'h61, "R9 long frame discarded");
    chk_irq(3'b101, "R9 no ready on long frame");
    rd(6'h05, 8'h10, "R9 length unchanged");

    frame(0, 8'h00);
    rd(6'h01, 8'h61, "R10 empty frame discarded");
    chk_irq(3'b101, "R10 no ready on empty frame");

    wr(6'h00, 8'h0F);
    rd(6'h01, 8'h00, "R7 full clear");
    chk_irq(3'b000, "R7 ready cleared");
    wr(6'h00, 8'h08);

    wr(6'h00, 8'h00);
    rd(6'h00, 8'h00, "R11 ctrl single mode");
    frame(2, 8'h20);
    rd(6'h01, 8'h01, "R11 slot0 used");
    frame(2, 8'h30);
    rd(6'h01, 8'h41, "R11 second frame dropped");
    rd(6'h10, 8'h20, "R11 slot0 content kept");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule